// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block is the per-channel datapath of a legacy-compatible DMA engine. Software programs a 16-bit start address, a low page byte, an optional high page byte and a transfer count stored as "transfers minus one". While the channel is unmasked, each accepted transfer strobe advances the current address by one and lowers the count by one. The block presents the 32-bit physical address of the transfer in progress.

A build parameter selects byte or word transfers. In byte mode the low page byte fills address bits 23:16 above the 16-bit register. In word mode the register is shifted up one place to bits 16:1, bit 0 is held at zero and page bit 0 is dropped, so one page covers 128K bytes. Unless the high page byte has been written since the last low page write, the address wraps inside its page and the page bits never change. Writing the high page byte as the last setup step turns the page bytes into the upper part of one counter that takes the carry out of the address register. When the count passes from 0x0000 to 0xFFFF, the block pulses a terminal-count flag. It then either reloads the programmed address and count (auto-initialise) or masks itself.

Top module: `dma_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, the channel is masked, the current address, count, page and high page are zero, the high page carry is disabled and the terminal-count flag is low.
- R2: In byte mode (WORD_MODE=0), bus_addr = {high page[7:0], page[7:0], current address[15:0]}.
- R3: In word mode (WORD_MODE=1), bus_addr = {high page[7:0], page[7:1], current address[15:0], 1'b0}. Page bit 0 has no effect and bus_addr[0] is always 0.
- R4: An accepted strobe adds one to the current address and subtracts one from the current count. Both changes are visible in the cycle after the strobe edge.
- R5: While the high page carry is disabled, an address step from 0xFFFF wraps to 0x0000 and the page field of bus_addr does not change.
- R6: Writing the high page byte enables the carry. With the carry enabled, a step from address 0xFFFF adds one page unit to {high page, page}: +1 in byte mode and +2 in word mode, with the carry passing into the high page. Writing the low page byte disables the carry and clears the high page to zero.
- R7: A strobe accepted at count 0x0000 leaves the count at 0xFFFF and raises tc for exactly the following cycle.
- R8: When auto_init is low at terminal count, the channel masks itself. Later strobes change neither the address nor the count.
- R9: When auto_init is high at terminal count, the current address and count reload the last programmed values, the page bytes keep their values and the channel stays unmasked.
- R10: A strobe is ignored while the channel is masked, and also in any cycle in which any of the four load strobes is high.
- R11: A pulse on unmask clears the mask. Loading the address or the count sets both the reload value and the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_addr | input | 1 | Load start address |
| ld_addr_val | input | 16 | Start address value |
| ld_count | input | 1 | Load count |
| ld_count_val | input | 16 | Count as transfers minus one |
| ld_page | input | 1 | Load low page byte; disables carry and clears the high page |
| ld_page_val | input | 8 | Low page value |
| ld_hipage | input | 1 | Load high page byte; enables carry |
| ld_hipage_val | input | 8 | High page value |
| auto_init | input | 1 | Reload at terminal count instead of masking |
| unmask | input | 1 | Clear the channel mask |
| xfer_strobe | input | 1 | One transfer completes at this edge |
| bus_addr | output | 32 | Physical address of the current transfer |
| cur_count | output | 16 | Remaining transfers minus one |
| tc | output | 1 | Terminal-count pulse |
| masked | output | 1 | Channel mask state |

## Verification
The assertions assume that the inputs are driven between clock edges and hold their values until the next edge. They also assume that auto_init is a level input sampled at the edge that produces terminal count. Because reload values may be zero, they do not assume that terminal counts are spread apart. The stimulus changes inputs only on the falling edge. The random phase raises loads with low probability, so long strobe runs reach address and count wraps. Directed sequences start the address at 0xFFFE or 0xFFFF so that page carries and wraps occur in both modes.

// File: rtl/dma_gen_pkg.sv
// Shared widths and the load-strobe bundle for the DMA address generator.
package dma_gen_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned PAGE_W = 8;

    typedef struct packed {
        logic addr;
        logic count;
        logic page;
        logic hipage;
    } prog_we_t;
endpackage

// File: rtl/dma_addr_ctr.sv
// Current/base transfer address register.
// Assumes a load has priority over reload, and reload has priority over step.
// carry reports a step taken from the all-ones value.
module dma_addr_ctr #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          reload,
    output logic [AW-1:0] cur,
    output logic          carry
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] cur_q;

    // Hold the reload value and advance the working address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            base_q <= load_val;
            cur_q  <= load_val;
        end else if (reload) begin
            cur_q <= base_q;
        end else if (step) begin
            cur_q <= cur_q + 1'b1;
        end
    end

    assign cur   = cur_q;
    assign carry = step & (&cur_q);
endmodule

// File: rtl/dma_count_ctr.sv
// Transfer counter holding "transfers minus one".
// Assumes the same priority as the address register: load, reload, step.
// wrap reports a step taken from zero.
module dma_count_ctr #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    input  logic          reload,
    output logic [CW-1:0] cur,
    output logic          wrap
);
    logic [CW-1:0] base_q;
    logic [CW-1:0] cur_q;

    // Hold the reload value and count down the working value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            base_q <= load_val;
            cur_q  <= load_val;
        end else if (reload) begin
            cur_q <= base_q;
        end else if (step) begin
            cur_q <= cur_q - 1'b1;
        end
    end

    assign cur  = cur_q;
    assign wrap = step & (cur_q == '0);
endmodule

// File: rtl/dma_page_ctr.sv
// Low and high page bytes with an optional shared carry counter.
// A low page write disables the carry and clears the high page.
// A high page write enables the carry. In word mode one page unit is 2,
// because page bit 0 is not part of the address.
module dma_page_ctr #(
    parameter int unsigned PW        = 8,
    parameter bit          WORD_MODE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          page_we,
    input  logic [PW-1:0] page_val,
    input  logic          hi_we,
    input  logic [PW-1:0] hi_val,
    input  logic          carry_in,
    output logic [PW-1:0] page,
    output logic [PW-1:0] hipage,
    output logic          hi_en
);
    localparam logic [2*PW-1:0] UNIT = WORD_MODE ? (2*PW)'(2) : (2*PW)'(1);

    logic [PW-1:0] page_q;
    logic [PW-1:0] hi_q;
    logic          en_q;
    logic [2*PW-1:0] joined_inc;

    assign joined_inc = {hi_q, page_q} + UNIT;

    // Page writes, then the carry increment of the joined page counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            hi_q   <= '0;
            en_q   <= 1'b0;
        end else if (page_we) begin
            page_q <= page_val;
            hi_q   <= '0;
            en_q   <= 1'b0;
        end else if (hi_we) begin
            hi_q <= hi_val;
            en_q <= 1'b1;
        end else if (carry_in && en_q) begin
            {hi_q, page_q} <= joined_inc;
        end
    end

    assign page   = page_q;
    assign hipage = hi_q;
    assign hi_en  = en_q;
endmodule

// File: rtl/dma_addr_gen.sv
// Per-channel DMA transfer address and count generator.
// Assumes the inputs are stable around the clock edge and a transfer strobe is
// one cycle per transfer. Any load in the same cycle as a strobe cancels the
// strobe. Byte or word addressing is fixed by WORD_MODE.
module dma_addr_gen
    import dma_gen_pkg::*;
#(
    parameter bit          WORD_MODE = 1'b0,
    parameter int unsigned AW        = REG_W,
    parameter int unsigned PW        = PAGE_W,
    localparam int unsigned BUS_W    = AW + 2 * PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_addr,
    input  logic [AW-1:0]    ld_addr_val,
    input  logic             ld_count,
    input  logic [AW-1:0]    ld_count_val,
    input  logic             ld_page,
    input  logic [PW-1:0]    ld_page_val,
    input  logic             ld_hipage,
    input  logic [PW-1:0]    ld_hipage_val,
    input  logic             auto_init,
    input  logic             unmask,
    input  logic             xfer_strobe,
    output logic [BUS_W-1:0] bus_addr,
    output logic [AW-1:0]    cur_count,
    output logic             tc,
    output logic             masked
);
    prog_we_t        we;
    logic            accept;
    logic            wrap;
    logic            reload;
    logic            addr_carry;
    logic [AW-1:0]   cur_addr;
    logic [PW-1:0]   page;
    logic [PW-1:0]   hipage;
    logic            hi_en;
    logic            mask_q;
    logic            tc_q;

    assign we     = '{addr: ld_addr, count: ld_count, page: ld_page, hipage: ld_hipage};
    assign accept = xfer_strobe & ~mask_q & ~(|we);
    assign reload = wrap & auto_init;

    dma_addr_ctr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (we.addr),
        .load_val (ld_addr_val),
        .step     (accept),
        .reload   (reload),
        .cur      (cur_addr),
        .carry    (addr_carry)
    );

    dma_count_ctr #(.CW(AW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (we.count),
        .load_val (ld_count_val),
        .step     (accept),
        .reload   (reload),
        .cur      (cur_count),
        .wrap     (wrap)
    );

    dma_page_ctr #(.PW(PW), .WORD_MODE(WORD_MODE)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .page_we  (we.page),
        .page_val (ld_page_val),
        .hi_we    (we.hipage),
        .hi_val   (ld_hipage_val),
        .carry_in (addr_carry & ~reload),
        .page     (page),
        .hipage   (hipage),
        .hi_en    (hi_en)
    );

    // Channel mask: set at terminal count without reload, cleared by unmask.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mask_q <= 1'b1;
        else if (wrap && !auto_init) mask_q <= 1'b1;
        else if (unmask)             mask_q <= 1'b0;
    end

    // Terminal-count pulse, one cycle after the wrapping strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= 1'b0;
        else        tc_q <= wrap;
    end

    generate
        if (WORD_MODE) begin : g_word
            assign bus_addr = {hipage, page[PW-1:1], cur_addr, 1'b0};
        end else begin : g_byte
            assign bus_addr = {hipage, page, cur_addr};
        end
    endgenerate

    assign tc     = tc_q;
    assign masked = mask_q;
endmodule

// File: rtl/dma_addr_gen_chk.sv
// Temporal checks for dma_addr_gen, attached to every instance by bind.
// Assumes the inputs are sampled at the rising edge.
module dma_addr_gen_chk #(
    parameter bit          WORD_MODE = 1'b0,
    parameter int unsigned AW        = 16,
    parameter int unsigned PW        = 8,
    localparam int unsigned BUS_W    = AW + 2 * PW,
    localparam int unsigned PG_LSB   = WORD_MODE ? AW + 1 : AW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_addr,
    input logic             ld_count,
    input logic             ld_page,
    input logic             ld_hipage,
    input logic             auto_init,
    input logic             unmask,
    input logic             xfer_strobe,
    input logic [BUS_W-1:0] bus_addr,
    input logic [AW-1:0]    cur_count,
    input logic             tc,
    input logic             masked,
    input logic             hi_en
);
    logic past_ok;
    logic no_load;
    logic took;

    assign no_load = !(ld_addr || ld_count || ld_page || ld_hipage);
    assign took    = xfer_strobe && !masked && no_load;

    // Marks the cycles in which $past reaches a cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_TC_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && tc |-> $past(cur_count) == '0); // R7

    AST_TC_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && tc && !$past(auto_init) |-> masked); // R8

    AST_AUTO_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && tc && $past(auto_init) |-> !masked); // R9

    AST_MASKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(masked) && $past(no_load) |-> $stable(bus_addr) && $stable(cur_count)); // R10

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(took) && $past(cur_count) != '0 |-> cur_count == $past(cur_count) - 1'b1); // R4

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(hi_en) && $past(no_load) |-> $stable(bus_addr[BUS_W-1:PG_LSB])); // R5

    generate
        if (WORD_MODE) begin : g_word_chk
            AST_WORD_A0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                bus_addr[0] == 1'b0); // R3
        end
    endgenerate
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.WORD_MODE(WORD_MODE), .AW(AW), .PW(PW)) u_chk (.*);

// File: tb/tb_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_addr = 0, ld_count = 0, ld_page = 0, ld_hipage = 0;
    logic [15:0] ld_addr_val = 0, ld_count_val = 0;
    logic [7:0]  ld_page_val = 0, ld_hipage_val = 0;
    logic        auto_init = 0, unmask = 0, xfer_strobe = 0;
    logic [31:0] bus_b, bus_w;
    logic [15:0] cnt_b, cnt_w;
    logic        tc_b, tc_w, mask_b, mask_w;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state, index 0 byte mode, 1 word mode
    logic [15:0] m_addr, m_base_addr, m_cnt, m_base_cnt;
    logic [7:0]  m_page [2];
    logic [7:0]  m_hi   [2];
    logic        m_hien, m_mask, m_tc;

    always #2.5 clk = ~clk;

    dma_addr_gen #(.WORD_MODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n),
        .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
        .ld_count(ld_count), .ld_count_val(ld_count_val),
        .ld_page(ld_page), .ld_page_val(ld_page_val),
        .ld_hipage(ld_hipage), .ld_hipage_val(ld_hipage_val),
        .auto_init(auto_init), .unmask(unmask), .xfer_strobe(xfer_strobe),
        .bus_addr(bus_b), .cur_count(cnt_b), .tc(tc_b), .masked(mask_b));

    dma_addr_gen #(.WORD_MODE(1'b1)) dut_w (
        .clk(clk), .rst_n(rst_n),
        .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
        .ld_count(ld_count), .ld_count_val(ld_count_val),
        .ld_page(ld_page), .ld_page_val(ld_page_val),
        .ld_hipage(ld_hipage), .ld_hipage_val(ld_hipage_val),
        .auto_init(auto_init), .unmask(unmask), .xfer_strobe(xfer_strobe),
        .bus_addr(bus_w), .cur_count(cnt_w), .tc(tc_w), .masked(mask_w));

    function automatic logic [31:0] exp_bus(int k);
        if (k == 0) return {m_hi[0], m_page[0], m_addr};
        return {m_hi[1], m_page[1][7:1], m_addr, 1'b0};
    endfunction

    task automatic model_reset();
        m_addr = 0; m_base_addr = 0; m_cnt = 0; m_base_cnt = 0;
        for (int k = 0; k < 2; k++) begin m_page[k] = 0; m_hi[k] = 0; end
        m_hien = 0; m_mask = 1; m_tc = 0;
    endtask

    // Next-state computation from the requirements, using the present inputs.
    task automatic model_step();
        logic any, acc, wrap, rel, carry;
        any   = ld_addr | ld_count | ld_page | ld_hipage;
        acc   = xfer_strobe & ~m_mask & ~any;
        wrap  = acc && (m_cnt == 16'h0000);
        rel   = wrap && auto_init;
        carry = acc && (m_addr == 16'hFFFF) && !rel;
        for (int k = 0; k < 2; k++) begin
            if (ld_page) begin m_page[k] = ld_page_val; m_hi[k] = 0; end
            else if (ld_hipage) m_hi[k] = ld_hipage_val;
            else if (carry && m_hien) {m_hi[k], m_page[k]} = {m_hi[k], m_page[k]} + ((k == 0) ? 16'd1 : 16'd2);
        end
        if (ld_page) m_hien = 0; else if (ld_hipage) m_hien = 1;
        if (ld_addr) begin m_addr = ld_addr_val; m_base_addr = ld_addr_val; end
        else if (rel) m_addr = m_base_addr;
        else if (acc) m_addr = m_addr + 1;
        if (ld_count) begin m_cnt = ld_count_val; m_base_cnt = ld_count_val; end
        else if (rel) m_cnt = m_base_cnt;
        else if (acc) m_cnt = m_cnt - 1;
        if (wrap && !auto_init) m_mask = 1; else if (unmask) m_mask = 0;
        m_tc = wrap;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "bus_addr byte", bus_b, exp_bus(0));
        chk(tag, "bus_addr word", bus_w, exp_bus(1));
        chk(tag, "count byte", {16'h0, cnt_b}, {16'h0, m_cnt});
        chk(tag, "count word", {16'h0, cnt_w}, {16'h0, m_cnt});
        chk(tag, "tc", {30'h0, tc_b, tc_w}, {30'h0, m_tc, m_tc});
        chk(tag, "masked", {30'h0, mask_b, mask_w}, {30'h0, m_mask, m_mask});
    endtask

    task automatic clear_in();
        ld_addr = 0; ld_count = 0; ld_page = 0; ld_hipage = 0;
        unmask = 0; xfer_strobe = 0;
    endtask

    // One clock: the model follows the edge, outputs are sampled at the falling edge.
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
        clear_in();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1;

        // Byte and word mapping, wrap inside page, terminal count without reload.
        ld_page = 1; ld_page_val = 8'h13; tick("R11");
        ld_addr = 1; ld_addr_val = 16'hFFFE; ld_count = 1; ld_count_val = 16'd3; tick("R11");
        xfer_strobe = 1; tick("R10");
        unmask = 1; tick("R11");
        compare("R2"); compare("R3");
        xfer_strobe = 1; tick("R4");
        xfer_strobe = 1; tick("R5");
        xfer_strobe = 1; tick("R4");
        xfer_strobe = 1; tick("R7");
        tick("R7");
        xfer_strobe = 1; tick("R8");
        xfer_strobe = 1; tick("R8");

        // High page carry, then auto-initialise.
        ld_page = 1; ld_page_val = 8'h34; tick("R6");
        ld_hipage = 1; ld_hipage_val = 8'hAB; tick("R6");
        ld_addr = 1; ld_addr_val = 16'hFFFF; ld_count = 1; ld_count_val = 16'd1; tick("R11");
        auto_init = 1; unmask = 1; tick("R11");
        xfer_strobe = 1; tick("R6");
        xfer_strobe = 1; tick("R9");
        tick("R9");
        xfer_strobe = 1; ld_count = 1; ld_count_val = 16'd5; tick("R10");
        xfer_strobe = 1; tick("R4");
        // Page carry into the high page byte.
        ld_page = 1; ld_page_val = 8'hFF; tick("R6");
        ld_hipage = 1; ld_hipage_val = 8'h01; tick("R6");
        ld_addr = 1; ld_addr_val = 16'hFFFF; tick("R6");
        xfer_strobe = 1; tick("R6");
        ld_page = 1; ld_page_val = 8'h21; tick("R6");
        auto_init = 0;

        // Random mix of strobes, loads and mode changes.
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 70) xfer_strobe = 1;
            else if (r < 73) begin
                ld_addr = 1;
                ld_addr_val = ($urandom % 2) ? 16'hFFF0 | 16'($urandom % 16) : 16'($urandom);
            end
            else if (r < 75) begin ld_count = 1; ld_count_val = 16'($urandom % 40); end
            else if (r < 76) begin ld_page = 1; ld_page_val = 8'($urandom); end
            else if (r < 78) begin ld_hipage = 1; ld_hipage_val = 8'($urandom); end
            else if (r < 85) unmask = 1;
            else if (r < 87) auto_init = ~auto_init;
            else if (r < 92) begin xfer_strobe = 1; unmask = 1; end
            if (($urandom % 50) == 0) xfer_strobe = 1;
            tick("R4");
        end
        summary();
    end
endmodule